// File: doc/BRIEF.md
# Prioritized Split Read/Write Request Queue

This block sits between a graphics port and the memory side. It takes address-and-command requests, with no data attached, one per cycle on a valid/ready input. It stores reads and writes in two separate queues. Data moves later over paths outside this block, so several requests can be queued before any data transfer starts. Each request carries a start address, a 3-bit length in 8-byte units and a priority flag. The block presents one chosen request at a time to the memory side on a valid/ready output.

The selection rules are as follows. A high-priority request wins over a low-priority one. Requests of the same direction and the same priority leave in the order they arrived. When the read head and the write head have the same priority, reads and writes take turns. Each issued write takes one write grant. At most four grants can be outstanding, and the memory side returns a grant with a one-cycle retire pulse. A write that finds no free grant waits, and reads continue to be issued in the meantime.

Back-pressure rules: `in_ready` is a function of `in_write` only, and it falls only when the queue for that direction is full. Taking a request out does not raise `in_ready` in the same cycle. The input and the output may both complete a transfer in the same cycle. The output request is not held while it waits: if a higher-priority request arrives, or a grant frees up, before `out_ready` is seen, the presented request can change.

Top module: `prio_rw_reqq`

## Requirements
- R1: A full read queue does not lower `in_ready` for writes, and a full write queue does not lower it for reads. Each direction is accepted on its own queue's space only.
- R2: Starting from empty, as many requests as the queue depth can be accepted on consecutive cycles while the output takes nothing.
- R3: A high-priority request is presented before any low-priority request that is eligible, both within one direction and across the two directions (`*_hipri` = 1 means high).
- R4: Requests of the same direction and the same priority are issued in arrival order.
- R5: When the read head and the write head are both eligible and have the same priority, the direction opposite to the last issued request is chosen. After reset, a read is chosen first.
- R6: At most GRANTS (default 4) writes are outstanding. With that many outstanding, no write is presented, but reads are still presented.
- R7: `grant_retire` lowers the outstanding count by one. A retire when the count is zero has no effect. An issue and a retire in the same cycle leave the count unchanged.
- R8: `out_len` equals the length that was accepted with the request. `out_nbytes` equals (len+1)*8, so length 0 means 8 bytes and length 7 means 64 bytes.
- R9: `in_ready` is low for a direction only when that direction's queue is full. An enqueue and a dequeue in the same cycle are both performed. The flags `rd_full`/`wr_full` and `rd_empty`/`wr_empty` reflect the occupancy of each queue.
- R10: A synchronous active-high `rst` empties both queues, clears the outstanding grant count and makes `out_valid` low.
- R11: `out_valid` is high whenever at least one queue has an eligible request. The presented request can change to a newly arrived higher-priority one before it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The queue for the offered direction has space |
| in_write | input | 1 | 1 = write request, 0 = read request |
| in_hipri | input | 1 | 1 = high priority |
| in_addr | input | 32 | Start address |
| in_len | input | 3 | Length in 8-byte units minus one |
| out_valid | output | 1 | A request is presented to memory |
| out_ready | input | 1 | The memory side takes the presented request |
| out_write | output | 1 | Direction of the presented request |
| out_hipri | output | 1 | Priority of the presented request |
| out_addr | output | 32 | Address of the presented request |
| out_len | output | 3 | Length field of the presented request |
| out_nbytes | output | 7 | Transfer size in bytes |
| grant_retire | input | 1 | One outstanding write grant is returned |
| grants_out | output | 3 | Number of outstanding write grants |
| rd_full | output | 1 | Read queue full |
| rd_empty | output | 1 | Read queue empty |
| wr_full | output | 1 | Write queue full |
| wr_empty | output | 1 | Write queue empty |

## Verification
The selection logic is driven with several input patterns:
- Runs of same-priority reads show whether arrival order holds.
- A mix of high and low reads shows whether high-priority requests overtake low ones without disturbing order within each class.
- A low read against a high write shows whether priority is applied across the two directions.
- Equal-priority reads and writes interleaved show whether the read/write turn-taking follows the last issued direction.
- A burst of five writes shows whether the grant cap is enforced while reads still pass.

Filling the read queue while offering a write separates independent back-pressure per direction from a shared full condition. An enqueue and a dequeue in the same cycle confirm that neither transfer is lost.

// File: rtl/pq_pkg.sv
package pq_pkg;
  parameter int ADDR_W = 32;
  parameter int LEN_W  = 3;
  localparam int NBYTES_W = LEN_W + 4;

  typedef struct packed {
    logic              hipri;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } req_t;

  // length field counts 8-byte units minus one
  function automatic logic [NBYTES_W-1:0] len_to_bytes(input logic [LEN_W-1:0] len);
    return (NBYTES_W'(len) + NBYTES_W'(1)) << 3;
  endfunction
endpackage

// File: rtl/pq_lane.sv
// Age-ordered collapsing queue: slot 0 is the oldest entry. The head is the
// oldest high-priority entry, or the oldest entry when none is high.
module pq_lane
  import pq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enq,
  input  req_t enq_req,
  input  logic deq,
  output req_t head,
  output logic avail,
  output logic full,
  output logic empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  req_t             ent [DEPTH];
  req_t             ent_nxt [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] sel;
  logic [CNT_W-1:0] ins_pos;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign avail = !empty;

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (i < int'(cnt)) && ent[i].hipri) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign head    = ent[sel];
  assign ins_pos = cnt - CNT_W'(deq);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    req_t shifted;
    if (g + 1 < DEPTH) begin : g_mid
      assign shifted = (deq && (IDX_W'(g) >= sel)) ? ent[g+1] : ent[g];
    end else begin : g_top
      assign shifted = ent[g];
    end
    always_comb begin
      if (enq && (ins_pos == CNT_W'(g))) ent_nxt[g] = enq_req;
      else                               ent_nxt[g] = shifted;
    end
    always_ff @(posedge clk) begin
      if (rst) ent[g] <= '0;
      else     ent[g] <= ent_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(enq) - CNT_W'(deq);
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    enq |-> (cnt < CNT_W'(DEPTH)) || deq);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
    deq |-> !empty);
  a_r3_head_is_high: assert property (@(posedge clk) disable iff (rst)
    (avail && ent[0].hipri) |-> head.hipri);
endmodule

// File: rtl/pq_credit.sv
module pq_credit #(
  parameter int GRANTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic retire,
  output logic [$clog2(GRANTS+1)-1:0] count,
  output logic avail
);
  localparam int GC_W = $clog2(GRANTS + 1);

  logic dec;
  assign dec   = retire && (count != '0);
  assign avail = (count < GC_W'(GRANTS));

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + GC_W'(issue) - GC_W'(dec);
  end

  a_r6_grant_cap: assert property (@(posedge clk) disable iff (rst)
    count <= GC_W'(GRANTS));
  a_r6_no_issue_at_cap: assert property (@(posedge clk) disable iff (rst)
    issue |-> avail);
  a_r7_idle_zero_retire: assert property (@(posedge clk) disable iff (rst)
    (retire && !issue && count == '0) |=> count == '0);
endmodule

// File: rtl/pq_arb.sv
module pq_arb (
  input  logic clk,
  input  logic rst,
  input  logic rd_avail,
  input  logic rd_hi,
  input  logic wr_avail,
  input  logic wr_hi,
  input  logic out_ready,
  output logic out_valid,
  output logic pick_wr,
  output logic rd_deq,
  output logic wr_deq
);
  logic last_wr;
  logic fire;

  always_comb begin
    if (rd_avail && wr_avail) begin
      if (rd_hi != wr_hi) pick_wr = wr_hi;
      else                pick_wr = !last_wr;
    end else begin
      pick_wr = wr_avail;
    end
  end

  assign out_valid = rd_avail || wr_avail;
  assign fire      = out_valid && out_ready;
  assign rd_deq    = fire && !pick_wr;
  assign wr_deq    = fire && pick_wr;

  always_ff @(posedge clk) begin
    if (rst)       last_wr <= 1'b1;
    else if (fire) last_wr <= pick_wr;
  end

  a_r3_read_not_over_high_write: assert property (@(posedge clk) disable iff (rst)
    (rd_deq && wr_avail && wr_hi) |-> rd_hi);
  a_r3_write_not_over_high_read: assert property (@(posedge clk) disable iff (rst)
    (wr_deq && rd_avail && rd_hi) |-> wr_hi);
  a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
    (rd_deq && wr_avail && (rd_hi == wr_hi)) |=> $past(last_wr));
  a_r9_one_dequeue: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_deq, wr_deq}));
endmodule

// File: rtl/prio_rw_reqq.sv
module prio_rw_reqq
  import pq_pkg::*;
#(
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8,
  parameter int GRANTS   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_write,
  input  logic                       in_hipri,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [LEN_W-1:0]           in_len,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_write,
  output logic                       out_hipri,
  output logic [ADDR_W-1:0]          out_addr,
  output logic [LEN_W-1:0]           out_len,
  output logic [NBYTES_W-1:0]        out_nbytes,
  input  logic                       grant_retire,
  output logic [$clog2(GRANTS+1)-1:0] grants_out,
  output logic                       rd_full,
  output logic                       rd_empty,
  output logic                       wr_full,
  output logic                       wr_empty
);
  localparam int GC_W = $clog2(GRANTS + 1);

  req_t in_req, rd_head, wr_head, sel_req;
  logic rd_enq, wr_enq, rd_deq, wr_deq;
  logic rd_avail, wr_has, wr_avail, credit_ok, pick_wr;

  assign in_req   = '{hipri: in_hipri, addr: in_addr, len: in_len};
  assign in_ready = in_write ? !wr_full : !rd_full;
  assign rd_enq   = in_valid && in_ready && !in_write;
  assign wr_enq   = in_valid && in_ready && in_write;

  pq_lane #(.DEPTH(RD_DEPTH)) u_rd (
    .clk(clk), .rst(rst), .enq(rd_enq), .enq_req(in_req), .deq(rd_deq),
    .head(rd_head), .avail(rd_avail), .full(rd_full), .empty(rd_empty)
  );

  pq_lane #(.DEPTH(WR_DEPTH)) u_wr (
    .clk(clk), .rst(rst), .enq(wr_enq), .enq_req(in_req), .deq(wr_deq),
    .head(wr_head), .avail(wr_has), .full(wr_full), .empty(wr_empty)
  );

  pq_credit #(.GRANTS(GRANTS)) u_cred (
    .clk(clk), .rst(rst), .issue(wr_deq), .retire(grant_retire),
    .count(grants_out), .avail(credit_ok)
  );

  assign wr_avail = wr_has && credit_ok;

  pq_arb u_arb (
    .clk(clk), .rst(rst),
    .rd_avail(rd_avail), .rd_hi(rd_head.hipri),
    .wr_avail(wr_avail), .wr_hi(wr_head.hipri),
    .out_ready(out_ready), .out_valid(out_valid), .pick_wr(pick_wr),
    .rd_deq(rd_deq), .wr_deq(wr_deq)
  );

  assign sel_req    = pick_wr ? wr_head : rd_head;
  assign out_write  = pick_wr;
  assign out_hipri  = sel_req.hipri;
  assign out_addr   = sel_req.addr;
  assign out_len    = sel_req.len;
  assign out_nbytes = len_to_bytes(sel_req.len);

  a_r6_write_needs_grant: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_write) |-> grants_out < GC_W'(GRANTS));
  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rd_empty && wr_empty && grants_out == '0 && !out_valid));
  a_r1_read_full_keeps_writes: assert property (@(posedge clk) disable iff (rst)
    (in_write && !wr_full) |-> in_ready);
  a_r11_valid_when_pending: assert property (@(posedge clk) disable iff (rst)
    !rd_empty |-> out_valid);
endmodule

// File: tb/sim_prio_rw_reqq.sv
module sim_prio_rw_reqq;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0, in_write = 0, in_hipri = 0;
  logic [31:0] in_addr = 0;
  logic [2:0]  in_len = 0;
  logic        out_ready = 0, grant_retire = 0;
  logic        in_ready, out_valid, out_write, out_hipri;
  logic [31:0] out_addr;
  logic [2:0]  out_len;
  logic [6:0]  out_nbytes;
  logic [2:0]  grants_out;
  logic        rd_full, rd_empty, wr_full, wr_empty;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  prio_rw_reqq #(.RD_DEPTH(8), .WR_DEPTH(8), .GRANTS(4)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_hipri(in_hipri), .in_addr(in_addr), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_hipri(out_hipri), .out_addr(out_addr), .out_len(out_len),
    .out_nbytes(out_nbytes), .grant_retire(grant_retire), .grants_out(grants_out),
    .rd_full(rd_full), .rd_empty(rd_empty), .wr_full(wr_full), .wr_empty(wr_empty)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input bit w, input bit hi,
                      input logic [31:0] a, input logic [2:0] l);
    @(negedge clk);
    in_valid = 1; in_write = w; in_hipri = hi; in_addr = a; in_len = l;
    #1 chk({tag, " accept"}, in_ready, 1);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic pop(input string tag, input bit w, input logic [31:0] a);
    @(negedge clk);
    #1 chk({tag, " valid"}, out_valid, 1);
    chk({tag, " dir"}, out_write, w);
    chk({tag, " addr"}, out_addr, a);
    out_ready = 1;
    @(posedge clk);
    #1 out_ready = 0;
  endtask

  task automatic retire();
    @(negedge clk);
    grant_retire = 1;
    @(posedge clk);
    #1 grant_retire = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      out_ready = 1;
      grant_retire = (grants_out != 0);
      @(posedge clk);
      #1 out_ready = 0; grant_retire = 0;
    end
    while (grants_out != 0) retire();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R10 rd_empty", rd_empty, 1);
    chk("R10 wr_empty", wr_empty, 1);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 grants", grants_out, 0);
    chk("R9 ready empty", in_ready, 1);
  endtask

  task automatic t_fifo_len();
    push("R4", 0, 0, 32'h100, 3'd0);
    push("R4", 0, 0, 32'h200, 3'd3);
    push("R4", 0, 0, 32'h300, 3'd7);
    @(negedge clk); #1;
    chk("R8 len0", out_len, 0);
    chk("R8 bytes8", out_nbytes, 8);
    pop("R4 first", 0, 32'h100);
    @(negedge clk); #1;
    chk("R8 len3", out_len, 3);
    chk("R8 bytes32", out_nbytes, 32);
    pop("R4 second", 0, 32'h200);
    @(negedge clk); #1;
    chk("R8 bytes64", out_nbytes, 64);
    pop("R4 third", 0, 32'h300);
    @(negedge clk); #1 chk("R9 rd_empty after", rd_empty, 1);
  endtask

  task automatic t_prio();
    push("R3", 0, 0, 32'hA0, 0);
    @(negedge clk); #1 chk("R11 offer lo", out_addr, 32'hA0);
    push("R3", 0, 0, 32'hB0, 0);
    push("R3", 0, 1, 32'hC0, 0);
    @(negedge clk); #1 chk("R11 offer switches", out_addr, 32'hC0);
    push("R3", 0, 1, 32'hD0, 0);
    pop("R3 hi1", 0, 32'hC0);
    pop("R3 hi2 R4", 0, 32'hD0);
    pop("R4 lo1", 0, 32'hA0);
    pop("R4 lo2", 0, 32'hB0);
  endtask

  task automatic t_cross();
    push("R3", 0, 0, 32'h1000, 0);
    push("R3", 1, 1, 32'h2000, 0);
    pop("R3 high write first", 1, 32'h2000);
    pop("R3 low read", 0, 32'h1000);
    @(negedge clk); #1 chk("R7 one grant", grants_out, 1);
    retire();
    @(negedge clk); #1 chk("R7 retired", grants_out, 0);
  endtask

  task automatic t_rr();
    // last issued was a read, so a write is chosen first
    push("R5", 0, 0, 32'h11, 0);
    push("R5", 0, 0, 32'h12, 0);
    push("R5", 1, 0, 32'h21, 0);
    push("R5", 1, 0, 32'h22, 0);
    pop("R5 w1", 1, 32'h21);
    pop("R5 r1", 0, 32'h11);
    pop("R5 w2", 1, 32'h22);
    pop("R5 r2", 0, 32'h12);
    retire(); retire();
  endtask

  task automatic t_grants();
    for (int i = 0; i < 5; i++) push("R6", 1, 0, 32'h500 + i, 0);
    for (int i = 0; i < 4; i++) pop("R6 w", 1, 32'h500 + i);
    @(negedge clk); #1;
    chk("R6 grants at cap", grants_out, 4);
    chk("R6 fifth held", out_valid, 0);
    push("R6", 0, 0, 32'h777, 0);
    pop("R6 read passes", 0, 32'h777);
    retire();
    @(negedge clk); #1 chk("R7 decrement", grants_out, 3);
    pop("R6 fifth after retire", 1, 32'h504);
    for (int i = 0; i < 4; i++) retire();
    @(negedge clk); #1 chk("R7 all retired", grants_out, 0);
    retire();
    @(negedge clk); #1 chk("R7 retire at zero", grants_out, 0);
    push("R7", 1, 0, 32'h600, 0);
    pop("R7 w", 1, 32'h600);
    push("R7", 1, 0, 32'h601, 0);
    @(negedge clk);
    out_ready = 1; grant_retire = 1;
    #1 chk("R7 same-cycle addr", out_addr, 32'h601);
    @(posedge clk);
    #1 out_ready = 0; grant_retire = 0;
    @(negedge clk); #1 chk("R7 issue+retire", grants_out, 1);
    retire();
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) push("R2 back-to-back", 0, 0, 32'h900 + i, 0);
    @(negedge clk);
    in_valid = 0; in_write = 0;
    #1 chk("R9 rd_full", rd_full, 1);
    chk("R9 read ready low", in_ready, 0);
    in_write = 1;
    #1 chk("R1 write ready", in_ready, 1);
    push("R1", 1, 0, 32'hF00, 0);
    @(negedge clk); #1 chk("R1 write stored", wr_empty, 0);
    drain();
    @(negedge clk); #1;
    chk("R9 drained rd", rd_empty, 1);
    chk("R9 drained wr", wr_empty, 1);
  endtask

  task automatic t_simul();
    push("R9", 0, 0, 32'hAA, 0);
    @(negedge clk);
    in_valid = 1; in_write = 0; in_hipri = 0; in_addr = 32'hBB; out_ready = 1;
    #1 chk("R9 simul ready", in_ready, 1);
    chk("R9 simul out", out_addr, 32'hAA);
    @(posedge clk);
    #1 in_valid = 0; out_ready = 0;
    pop("R9 kept", 0, 32'hBB);
    @(negedge clk); #1 chk("R9 empty after", rd_empty, 1);
  endtask

  task automatic t_reset_mid();
    push("R10", 0, 0, 32'h1, 0);
    push("R10", 1, 0, 32'h2, 0);
    pop("R10 w", 1, 32'h2);
    do_reset();
    #1;
    chk("R10 mid rd_empty", rd_empty, 1);
    chk("R10 mid wr_empty", wr_empty, 1);
    chk("R10 mid grants", grants_out, 0);
    chk("R10 mid valid", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_fifo_len();
    t_prio();
    t_cross();
    t_rr();
    t_grants();
    t_full();
    t_simul();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule